// File: doc/BRIEF.md
# Prefetch Burst Read Termination Controller

This block sits in a bus target that answers prefetchable burst reads from a small response buffer. The interconnect behind the target fills the buffer in reply to read requests. Every clock the controller picks one of three actions toward the initiator: hand over a buffered word, stretch the burst with a wait state, or disconnect. A registered counter of words still owed by the interconnect tells an empty buffer that may refill apart from one that never will.

Once a burst ends, by disconnect or by the initiator finishing, the controller flushes the buffer. It then drains: words the interconnect still returns are dropped on arrival. The buffer is reported free only after the last owed word has come back. Bursts that would cross their region boundary, and bursts in cacheline wrap order, are cut to a single data phase. A busy flag covers the drain, and new bursts are refused while it is high.

Top module: `prb_term_ctrl`

## Requirements
- R1: While `rst` is high and on the first edge after it, `rd_valid`, `rd_wait`, `rd_disc` and `drain_busy` are 0 and `buf_free` is 1 (idle, buffer empty, nothing outstanding).
- R2: During a burst, a buffered word is presented with `rd_valid`=1 on `rd_data` one cycle after the decision edge. Words leave in the order they arrived on `rsp_data`.
- R3: During a burst, a cycle with an empty buffer and zero outstanding words produces `rd_disc`=1 alone, and `buf_free`=1 in the same output cycle.
- R4: A cycle with an empty buffer and a nonzero outstanding count produces `rd_wait`=1 alone, as long as fewer than WAIT_LIMIT (8) wait cycles have passed since the burst start or the last data phase. A data phase resets this count.
- R5: After WAIT_LIMIT consecutive wait cycles, the next empty cycle produces `rd_disc`=1 alone. Then `drain_busy`=1, every returned word is dropped and never shown on `rd_valid`, and `buf_free` returns the cycle the last owed word arrives. If none is owed, it returns at once.
- R6: `ini_done` during a burst ends it with no data, wait or disconnect output. Buffered words are discarded, and in-flight words are drained as in R5.
- R7: `burst_cross` or `burst_wrap`, sampled with `burst_start`, limits the burst to one data phase. That phase carries `rd_valid`=1 and `rd_disc`=1 together.
- R8: `rd_disc` is high for exactly one cycle per burst, either with the final data phase or alone.
- R9: `burst_start` is ignored while a burst is active or while draining (`drain_busy`=1). It is accepted only when idle.
- R10: `req_issue` is counted only during a burst or together with an accepted `burst_start`, and only while buffered plus outstanding words are fewer than DEPTH (8). `rsp_valid` with nothing outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_start | input | 1 | Initiator begins a burst (taken only when idle) |
| burst_cross | input | 1 | Burst would cross its region boundary |
| burst_wrap | input | 1 | Burst uses cacheline wrap order |
| ini_done | input | 1 | Initiator completes the burst normally |
| req_issue | input | 1 | One read request issued to the interconnect |
| rsp_valid | input | 1 | Interconnect returns one word |
| rsp_data | input | DATA_W | Returned word |
| rd_valid | output | 1 | Data phase this cycle |
| rd_data | output | DATA_W | Data word of the data phase |
| rd_wait | output | 1 | Wait state inserted |
| rd_disc | output | 1 | Disconnect the initiator |
| buf_free | output | 1 | Response buffer available for a new burst |
| drain_busy | output | 1 | Discarding late words after a burst ended |

## Verification
The assertions assume only that inputs are synchronous. Out-of-range behaviour, such as a return with nothing owed or a request past the buffer depth, is absorbed by the block's own gating, so the occupancy and output-exclusion properties hold for any input sequence. The stimulus keeps the interconnect's return probability above zero in every burst, so each drain finishes. It also mixes slow-return bursts that reach the timeout with fast ones that never wait.

// File: rtl/prb_pkg.sv
package prb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DRAIN  = 2'd2
  } prb_state_e;
endpackage

// File: rtl/prb_resp_buf.sv
module prb_resp_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (pop) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_BUF_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push && !flush) |-> (count < CW'(DEPTH) || pop)); // R10
  AST_BUF_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0)); // R2
endmodule

// File: rtl/prb_outstanding.sv
module prb_outstanding #(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       inc_req,
  input  logic                       ret,
  input  logic                       drain_only,
  input  logic [$clog2(DEPTH+1)-1:0] buffered,
  output logic [$clog2(DEPTH+1)-1:0] outst,
  output logic [$clog2(DEPTH+1)-1:0] outst_nxt,
  output logic                       ret_taken
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW:0] LIMIT = (CW+1)'(DEPTH);

  logic inc_taken;
  logic [CW:0] occupied;

  always_comb begin
    occupied  = {1'b0, outst} + {1'b0, buffered};
    inc_taken = inc_req && !drain_only && (occupied < LIMIT);
    ret_taken = ret && (outst != '0);
    outst_nxt = outst;
    if (inc_taken && !ret_taken) outst_nxt = outst + 1'b1;
    if (!inc_taken && ret_taken) outst_nxt = outst - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) outst <= '0;
    else     outst <= outst_nxt;
  end

  AST_OUT_BOUND: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, outst} + {1'b0, buffered}) <= LIMIT); // R10
  AST_OUT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (outst == '0 && !inc_req) |=> (outst == '0)); // R10
endmodule

// File: rtl/prb_idle_timer.sv
module prb_idle_timer #(
  parameter int WAIT_LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic expired
);
  localparam int TW = $clog2(WAIT_LIMIT+1);
  logic [TW-1:0] cnt;

  assign expired = (cnt == TW'(WAIT_LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clear)         cnt <= '0;
    else if (tick && !expired) cnt <= cnt + 1'b1;
  end

  AST_TIMER_SAT: assert property (@(posedge clk) disable iff (rst)
    cnt <= TW'(WAIT_LIMIT)); // R4
  AST_TIMER_NO_TICK_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    expired |-> !tick); // R5
endmodule

// File: rtl/prb_term_ctrl.sv
module prb_term_ctrl
  import prb_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 8,
  parameter int WAIT_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              burst_start,
  input  logic              burst_cross,
  input  logic              burst_wrap,
  input  logic              ini_done,
  input  logic              req_issue,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_wait,
  output logic              rd_disc,
  output logic              buf_free,
  output logic              drain_busy
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int RW = $clog2(WAIT_LIMIT+2);

  prb_state_e state, state_nxt;
  logic       single_q;
  logic       start, leave, pop, push;
  logic       valid_d, wait_d, disc_d;
  logic       tmr_expired, ret_taken;
  logic [CW-1:0] buf_count, outst, outst_nxt;

  assign start = (state == ST_IDLE) && burst_start;

  prb_resp_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .flush(leave), .push(push), .push_data(rsp_data),
    .pop(pop), .rd_data(rd_data), .count(buf_count)
  );

  prb_outstanding #(.DEPTH(DEPTH)) u_outst (
    .clk(clk), .rst(rst), .inc_req(req_issue && ((state == ST_ACTIVE) || start)),
    .ret(rsp_valid), .drain_only(state == ST_DRAIN), .buffered(buf_count),
    .outst(outst), .outst_nxt(outst_nxt), .ret_taken(ret_taken)
  );

  prb_idle_timer #(.WAIT_LIMIT(WAIT_LIMIT)) u_timer (
    .clk(clk), .rst(rst), .clear(start || pop), .tick(wait_d), .expired(tmr_expired)
  );

  // per-cycle decision toward the initiator
  always_comb begin
    valid_d = 1'b0;
    wait_d  = 1'b0;
    disc_d  = 1'b0;
    leave   = 1'b0;
    pop     = 1'b0;
    if (state == ST_ACTIVE) begin
      if (ini_done) begin
        leave = 1'b1;
      end else if (buf_count != '0) begin
        pop     = 1'b1;
        valid_d = 1'b1;
        if (single_q) begin
          disc_d = 1'b1;
          leave  = 1'b1;
        end
      end else if (outst == '0) begin
        disc_d = 1'b1;
        leave  = 1'b1;
      end else if (!tmr_expired) begin
        wait_d = 1'b1;
      end else begin
        disc_d = 1'b1;
        leave  = 1'b1;
      end
    end
    push = ret_taken && (state == ST_ACTIVE) && !leave;
  end

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE:   if (burst_start) state_nxt = ST_ACTIVE;
      ST_ACTIVE: if (leave) state_nxt = (outst_nxt == '0) ? ST_IDLE : ST_DRAIN;
      ST_DRAIN:  if (outst_nxt == '0) state_nxt = ST_IDLE;
      default:   state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      single_q   <= 1'b0;
      rd_valid   <= 1'b0;
      rd_wait    <= 1'b0;
      rd_disc    <= 1'b0;
      buf_free   <= 1'b1;
      drain_busy <= 1'b0;
    end else begin
      state      <= state_nxt;
      if (start) single_q <= burst_cross || burst_wrap;
      rd_valid   <= valid_d;
      rd_wait    <= wait_d;
      rd_disc    <= disc_d;
      buf_free   <= (state_nxt == ST_IDLE);
      drain_busy <= (state_nxt == ST_DRAIN);
    end
  end

  // monitors fed from the ports, kept apart from the decision logic
  logic [RW-1:0] wait_run;
  logic          mon_single;
  always_ff @(posedge clk) begin
    if (rst) begin
      wait_run   <= '0;
      mon_single <= 1'b0;
    end else begin
      wait_run <= rd_wait ? wait_run + 1'b1 : '0;
      if (buf_free && burst_start) mon_single <= burst_cross || burst_wrap;
    end
  end

  AST_WAIT_ALONE: assert property (@(posedge clk) disable iff (rst)
    rd_wait |-> (!rd_valid && !rd_disc)); // R4
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    rd_wait |-> (wait_run < RW'(WAIT_LIMIT))); // R4
  AST_FREE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    !(buf_free && drain_busy)); // R5
  AST_DRAIN_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (drain_busy && $past(drain_busy)) |-> !rd_valid); // R5
  AST_SINGLE_PHASE: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && mon_single) |-> rd_disc); // R7
  AST_DISC_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_disc |=> !rd_disc); // R8
  AST_DRAIN_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (drain_busy && burst_start) |=> !rd_valid && !rd_wait); // R9
endmodule

// File: tb/prb_term_ctrl_test.sv
`timescale 1ns/1ps
module prb_term_ctrl_test;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 8;
  localparam int LIMIT  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic burst_start = 0, burst_cross = 0, burst_wrap = 0, ini_done = 0;
  logic req_issue = 0, rsp_valid = 0;
  logic [DATA_W-1:0] rsp_data = '0;
  logic rd_valid, rd_wait, rd_disc, buf_free, drain_busy;
  logic [DATA_W-1:0] rd_data;

  always #2 clk = ~clk;

  prb_term_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .WAIT_LIMIT(LIMIT)) uut (
    .clk(clk), .rst(rst), .burst_start(burst_start), .burst_cross(burst_cross),
    .burst_wrap(burst_wrap), .ini_done(ini_done), .req_issue(req_issue),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_wait(rd_wait), .rd_disc(rd_disc), .buf_free(buf_free), .drain_busy(drain_busy)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  string cur_tag = "R1";

  // reference model: 0 idle, 1 burst, 2 drain
  int m_st = 0, m_out = 0, m_idle = 0;
  bit m_single = 0;
  logic [DATA_W-1:0] m_q[$];
  bit e_valid, e_wait, e_disc, e_free, e_busy;
  logic [DATA_W-1:0] e_data;
  logic [DATA_W-1:0] next_word = 32'h1000;

  task automatic model_reset();
    m_st = 0; m_out = 0; m_idle = 0; m_single = 0; m_q.delete();
    e_valid = 0; e_wait = 0; e_disc = 0; e_free = 1; e_busy = 0;
  endtask

  task automatic model_edge();
    bit inc, dec, leave;
    int onext, nst;
    inc = req_issue && (m_st == 1 || (m_st == 0 && burst_start)) && (m_out + m_q.size() < DEPTH);
    dec = rsp_valid && (m_out != 0);
    e_valid = 0; e_wait = 0; e_disc = 0; leave = 0;
    nst = m_st;
    if (m_st == 1) begin
      if (ini_done) leave = 1;
      else if (m_q.size() > 0) begin
        e_valid = 1; e_data = m_q.pop_front(); m_idle = 0;
        if (m_single) begin e_disc = 1; leave = 1; end
      end else if (m_out == 0) begin e_disc = 1; leave = 1; end
      else if (m_idle < LIMIT) begin e_wait = 1; m_idle++; end
      else begin e_disc = 1; leave = 1; end
      if (dec && !leave) m_q.push_back(rsp_data);
    end
    onext = m_out + (inc ? 1 : 0) - (dec ? 1 : 0);
    if (m_st == 0 && burst_start) begin
      nst = 1; m_single = burst_cross || burst_wrap; m_idle = 0;
    end else if (m_st == 1 && leave) begin
      m_q.delete(); nst = (onext == 0) ? 0 : 2;
    end else if (m_st == 2 && onext == 0) nst = 0;
    m_out = onext; m_st = nst;
    e_free = (nst == 0); e_busy = (nst == 2);
  endtask

  task automatic chk(input string what, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("rd_valid (R2)", 32'(rd_valid), 32'(e_valid));
    chk("rd_wait (R4)", 32'(rd_wait), 32'(e_wait));
    chk("rd_disc (R8)", 32'(rd_disc), 32'(e_disc));
    chk("buf_free (R5)", 32'(buf_free), 32'(e_free));
    chk("drain_busy (R9)", 32'(drain_busy), 32'(e_busy));
    if (e_valid) chk("rd_data (R2)", rd_data, e_data);
  endtask

  // one cycle: drive at negedge, model on posedge, compare at next negedge
  task automatic cyc(input bit bs, input bit cr, input bit wr, input bit dn, input bit rq, input bit rv);
    burst_start = bs; burst_cross = cr; burst_wrap = wr; ini_done = dn;
    req_issue = rq; rsp_valid = rv;
    if (rv) begin rsp_data = next_word; next_word = next_word + 32'h11; end
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    compare_all();
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    compare_all();

    // R3: burst with nothing requested ends at once
    cur_tag = "R3";
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    idle_cycles(2);

    // R2: words delivered in arrival order
    cur_tag = "R2";
    cyc(1, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    idle_cycles(3);

    // R4/R5: stall, timeout, then drain of late words
    cur_tag = "R4";
    cyc(1, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < LIMIT; i++) cyc(0, 0, 0, 0, 0, 0);
    cur_tag = "R5";
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    cur_tag = "R9";
    cyc(1, 0, 0, 0, 1, 0);
    cur_tag = "R5";
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);
    idle_cycles(2);

    // R6: initiator completes with words buffered and in flight
    cur_tag = "R6";
    cyc(1, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);
    idle_cycles(2);

    // R7: boundary cross and wrap each give one phase
    cur_tag = "R7";
    cyc(1, 1, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    idle_cycles(2);
    cyc(1, 0, 1, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0);
    idle_cycles(2);

    // R10: request cap, stray returns, request while idle
    cur_tag = "R10";
    cyc(0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(1, 0, 0, 0, 1, 0);
    for (int i = 0; i < DEPTH + 3; i++) cyc(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < DEPTH + 4; i++) cyc(0, 0, 0, 0, 0, 1);
    idle_cycles(4);

    // constrained random traffic
    cur_tag = "RAND";
    begin
      int p_rsp;
      void'($urandom(32'h5EED_2024));
      p_rsp = 50;
      for (int i = 0; i < 6000; i++) begin
        bit bs, cr, wr, dn, rq, rv;
        bs = ($urandom % 100) < 25;
        cr = ($urandom % 100) < 10;
        wr = ($urandom % 100) < 10;
        dn = ($urandom % 100) < 3;
        rq = ($urandom % 100) < 45;
        if (bs && m_st == 0) p_rsp = (($urandom % 4) == 0) ? 4 : 20 + int'($urandom % 70);
        rv = int'($urandom % 100) < p_rsp;
        cyc(bs, cr, wr, dn, rq, rv);
      end
      for (int i = 0; i < 60; i++) cyc(0, 0, 0, 1, 0, 1);
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule